// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog Timer

This block is a supervision timer that counts ticks of a gated oscillator enable and raises a reset request when software stops servicing it. Software services it by writing a two-byte key, 0x55 and then 0xAA, to a key port before the selected time-out period runs out. A correct pair restarts the count from zero. Any other value, or a pair given in the wrong order, raises the reset request at once.

A 3-bit select input picks one of seven time-out lengths, and a select of zero turns the timer off. An optional window mode accepts key writes only in the last quarter of the period, and an early write is treated as a fault. A low-power stop input freezes the count unless a run-in-stop control is set.

The reset request is a pulse one clock wide. In the clock after the pulse, the timer holds its reset state. A parameter shortens all periods by the same power of two, so that a scaled copy can be exercised in a short run.

Top module: `wdt_keyseq`

## Requirements
- R1: After `rst` the request output `rst_req` is low, the key sequence is idle and the elapsed tick count is zero.
- R2: While `cfg_sel` is 0 the timer is off. The count is held at zero, key writes of any value are ignored and `rst_req` stays low.
- R3: The nonzero codes 1 to 7 of `cfg_sel` give periods of 2^(E-PERIOD_SHRINK) counted ticks, with E = 14, 16, 18, 20, 22, 23, 24 in code order. If no service happens, `rst_req` is high in the cycle after the edge that takes the period's last counted tick.
- R4: A write of 0x55 followed by a write of 0xAA, accepted on the edge of the 0xAA write, sets the count to zero. A full period of counted ticks must then pass before the next time-out.
- R5: A key write with any value other than 0x55 or 0xAA makes `rst_req` high in the next cycle.
- R6: Writing 0xAA while no 0x55 is pending, or writing 0x55 while one is already pending, makes `rst_req` high in the next cycle.
- R7: With `cfg_window` = 1, a key write sampled while the count is below three quarters of the period is a fault (`rst_req` high in the next cycle). A key write sampled at or above three quarters is accepted.
- R8: While `stop_mode` = 1 and `cfg_run_in_stop` = 0, the count is frozen. With `cfg_run_in_stop` = 1, counting goes on in stop mode.
- R9: A tick is counted only on edges where `tick_en` = 1. Otherwise the count holds.
- R10: `rst_req` is high for exactly one cycle. In that cycle key writes and ticks are ignored, and the count and key state return to their reset values.
- R11: A completing 0xAA write sampled on the same edge as the expiring tick counts as a service, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Gated oscillator tick enable, one tick per high cycle |
| cfg_sel | input | 3 | Period select, 0 turns the timer off |
| cfg_window | input | 1 | Window mode: keys accepted only in the last quarter |
| cfg_run_in_stop | input | 1 | Keep counting while stop mode is active |
| stop_mode | input | 1 | Low-power stop mode indication |
| key_wr | input | 1 | Key port write strobe |
| key_data | input | 8 | Key port write value |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The assertions assume that the configuration inputs stay constant while the timer runs. They are changed only during `rst` or while `cfg_sel` is zero. The assertions also assume that `PERIOD_SHRINK` leaves at least a four-tick period, so that the three-quarter boundary exists. The stimulus keeps to this. Every test first applies reset with the new configuration, leaves that configuration in place until the next reset, and uses a shrink of 10 for the bench instance. The window boundary and the service-at-expiry edge are reached by waiting on the reference model's own count, so the edge cases land on the exact sampling edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WDT_SEL_W   = 3;
    localparam int WDT_KEY_W   = 8;
    localparam int WDT_MAX_EXP = 24;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic run;
        logic clear;
    } tb_ctl_t;

    typedef struct packed {
        logic                 wr;
        logic [WDT_KEY_W-1:0] data;
    } key_req_t;

    function automatic int unsigned wdt_exp(input logic [WDT_SEL_W-1:0] sel,
                                            input int unsigned shrink);
        int unsigned e;
        case (sel)
            3'd1:    e = 14;
            3'd2:    e = 16;
            3'd3:    e = 18;
            3'd4:    e = 20;
            3'd5:    e = 22;
            3'd6:    e = 23;
            3'd7:    e = 24;
            default: e = 0;
        endcase
        return (e > shrink) ? (e - shrink) : 0;
    endfunction

endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase
    import wdt_pkg::*;
#(
    parameter int CNT_W         = 24,
    parameter int PERIOD_SHRINK = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WDT_SEL_W-1:0] sel,
    input  tb_ctl_t              ctl,
    output logic                 expire,
    output logic                 win_open
);

    localparam int PW = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    period;
    logic [PW-1:0]    win_start;
    logic [PW-1:0]    cnt_ext;
    int unsigned      shift_amt;

    always_comb begin
        shift_amt = wdt_exp(sel, PERIOD_SHRINK);
        period    = PW'(1) << shift_amt;
        win_start = period - (period >> 2);
        cnt_ext   = {1'b0, cnt_q};
        expire    = ctl.run && (cnt_ext >= (period - PW'(1)));
        win_open  = (cnt_ext >= win_start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.clear) begin
            cnt_q <= '0;
        end else if (ctl.run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !ctl.clear) |=> $stable(cnt_q));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (cnt_q == '0));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && !ctl.clear) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter logic [WDT_KEY_W-1:0] KEY_FIRST  = 8'h55,
    parameter logic [WDT_KEY_W-1:0] KEY_SECOND = 8'hAA
) (
    input  logic     clk,
    input  logic     rst,
    input  key_req_t req,
    input  logic     win_ok,
    input  logic     abort,
    output logic     svc_done,
    output logic     key_err
);

    key_state_e state_q, state_d;
    logic       arm_hit;

    always_comb begin
        svc_done = 1'b0;
        key_err  = 1'b0;
        arm_hit  = 1'b0;
        if (req.wr) begin
            if (!win_ok) begin
                key_err = 1'b1;
            end else if (req.data == KEY_FIRST) begin
                if (state_q == KEY_ARMED) key_err = 1'b1;
                else                      arm_hit = 1'b1;
            end else if (req.data == KEY_SECOND) begin
                if (state_q == KEY_ARMED) svc_done = 1'b1;
                else                      key_err  = 1'b1;
            end else begin
                key_err = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (abort || key_err) state_d = KEY_IDLE;
        else if (arm_hit)     state_d = KEY_ARMED;
        else if (svc_done)    state_d = KEY_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_IDLE;
        else     state_q <= state_d;
    end

    assert_arm_from_first_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == KEY_ARMED) |-> $past(req.wr && (req.data == KEY_FIRST)));

endmodule

// File: rtl/wdt_req_pulse.sv
module wdt_req_pulse (
    input  logic clk,
    input  logic rst,
    input  logic enabled,
    input  logic key_err,
    input  logic expire,
    input  logic svc_done,
    output logic fault,
    output logic rst_req
);

    always_comb begin
        fault = enabled && !rst_req && (key_err || (expire && !svc_done));
    end

    always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= fault;
    end

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_expiry_raises_R3: assert property (@(posedge clk) disable iff (rst)
        (enabled && !rst_req && expire && !svc_done) |=> rst_req);

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int PERIOD_SHRINK = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic [WDT_SEL_W-1:0] cfg_sel,
    input  logic                 cfg_window,
    input  logic                 cfg_run_in_stop,
    input  logic                 stop_mode,
    input  logic                 key_wr,
    input  logic [WDT_KEY_W-1:0] key_data,
    output logic                 rst_req
);

    localparam int CNT_W = WDT_MAX_EXP - PERIOD_SHRINK;

    logic     enabled;
    logic     expire;
    logic     win_open;
    logic     win_ok;
    logic     svc_done;
    logic     key_err;
    logic     fault;
    tb_ctl_t  ctl;
    key_req_t kreq;

    always_comb begin
        enabled   = (cfg_sel != '0);
        kreq.wr   = key_wr && enabled && !rst_req;
        kreq.data = key_data;
        win_ok    = !cfg_window || win_open;
        ctl.run   = enabled && !rst_req && tick_en && (!stop_mode || cfg_run_in_stop);
        ctl.clear = !enabled || rst_req || svc_done || fault;
    end

    wdt_timebase #(
        .CNT_W         (CNT_W),
        .PERIOD_SHRINK (PERIOD_SHRINK)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .sel      (cfg_sel),
        .ctl      (ctl),
        .expire   (expire),
        .win_open (win_open)
    );

    wdt_key_seq u_key_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (kreq),
        .win_ok   (win_ok),
        .abort    (fault || !enabled || rst_req),
        .svc_done (svc_done),
        .key_err  (key_err)
    );

    wdt_req_pulse u_req_pulse (
        .clk      (clk),
        .rst      (rst),
        .enabled  (enabled),
        .key_err  (key_err),
        .expire   (expire),
        .svc_done (svc_done),
        .fault    (fault),
        .rst_req  (rst_req)
    );

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel == '0) |=> !rst_req);

    assert_bad_value_R5: assert property (@(posedge clk) disable iff (rst)
        (kreq.wr && (key_data != 8'h55) && (key_data != 8'hAA)) |=> rst_req);

    assert_early_write_R7: assert property (@(posedge clk) disable iff (rst)
        (kreq.wr && cfg_window && !win_open) |=> rst_req);

endmodule

// File: tb/tb_wdt_keyseq.sv
`timescale 1ns/1ps
module tb_wdt_keyseq;

    localparam int SHRINK = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic [2:0] cfg_sel = 3'd1;
    logic       cfg_window = 1'b0;
    logic       cfg_run_in_stop = 1'b0;
    logic       stop_mode = 1'b0;
    logic       key_wr = 1'b0;
    logic [7:0] key_data = 8'h00;
    logic       rst_req;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    pulses = 0;

    always #10 clk = ~clk;

    wdt_keyseq #(.PERIOD_SHRINK(SHRINK)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_sel(cfg_sel),
        .cfg_window(cfg_window), .cfg_run_in_stop(cfg_run_in_stop),
        .stop_mode(stop_mode), .key_wr(key_wr), .key_data(key_data),
        .rst_req(rst_req)
    );

    // behavioural reference
    int m_cnt = 0;
    bit m_armed = 0;
    bit m_rq = 0;

    function automatic int per_of(input logic [2:0] s);
        int e;
        case (s)
            3'd1: e = 14; 3'd2: e = 16; 3'd3: e = 18; 3'd4: e = 20;
            3'd5: e = 22; 3'd6: e = 23; 3'd7: e = 24; default: e = SHRINK;
        endcase
        return 1 << (e - SHRINK);
    endfunction

    always @(posedge clk) begin
        bit f, s, run;
        int per;
        f = 0; s = 0;
        if (rst) begin
            m_cnt = 0; m_armed = 0; m_rq = 0;
        end else if (m_rq || cfg_sel == 3'd0) begin
            m_rq = 0; m_cnt = 0; m_armed = 0;
        end else begin
            per = per_of(cfg_sel);
            run = tick_en && (!stop_mode || cfg_run_in_stop);
            if (key_wr) begin
                if (cfg_window && m_cnt < per - per / 4) f = 1;
                else if (key_data == 8'h55) begin
                    if (m_armed) f = 1; else m_armed = 1;
                end else if (key_data == 8'hAA) begin
                    if (m_armed) s = 1; else f = 1;
                end else f = 1;
            end
            if (!f && !s && run && m_cnt >= per - 1) f = 1;
            if (f) begin
                m_rq = 1; m_cnt = 0; m_armed = 0;
            end else if (s) begin
                m_cnt = 0; m_armed = 0;
            end else if (run) m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (rst_req !== m_rq) begin
                n_err++;
                $display("FAIL %s model compare: actual=%0b expected=%0b at %0t",
                         cur_req, rst_req, m_rq, $time);
            end
            if (rst_req === 1'b1) pulses++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [2:0] s, input bit w, input bit cis);
        rst = 1'b1; key_wr = 1'b0; stop_mode = 1'b0; tick_en = 1'b1;
        cfg_sel = s; cfg_window = w; cfg_run_in_stop = cis;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic key_write(input logic [7:0] d);
        key_wr = 1'b1; key_data = d;
        @(negedge clk);
        key_wr = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_req !== 1'b1 && n < 100000);
    endtask

    task automatic wait_cnt(input int v);
        while (m_cnt != v) @(negedge clk);
    endtask

    initial begin
        #(20ns * 200000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n, p0;
        // R1 reset state
        cur_req = "R1";
        apply_reset(3'd1, 0, 0);
        chk(rst_req == 1'b0, "R1 request low after reset", int'(rst_req), 0);
        measure(n);
        chk(n == 16, "R1 count starts at zero", n, 16);

        // R3 all periods
        cur_req = "R3";
        for (int s = 1; s <= 7; s++) begin
            apply_reset(3'(s), 0, 0);
            measure(n);
            chk(n == per_of(3'(s)), "R3 period length", n, per_of(3'(s)));
        end

        // R4 service restarts
        cur_req = "R4";
        apply_reset(3'd1, 0, 0);
        p0 = pulses;
        for (int i = 0; i < 6; i++) begin
            repeat (8) @(negedge clk);
            key_write(8'h55);
            key_write(8'hAA);
        end
        chk(pulses == p0, "R4 no request while serviced", pulses - p0, 0);
        measure(n);
        chk(n == 16, "R4 full period after service", n, 16);

        // R5 bad value, R10 pulse width and ignore
        cur_req = "R5";
        apply_reset(3'd1, 0, 0);
        repeat (3) @(negedge clk);
        key_write(8'h33);
        chk(rst_req == 1'b1, "R5 bad value request", int'(rst_req), 1);
        cur_req = "R10";
        key_write(8'h01);
        chk(rst_req == 1'b0, "R10 single cycle, write ignored", int'(rst_req), 0);
        measure(n);
        chk(n == 16, "R10 state cleared after pulse", n, 16);

        // R6 order errors
        cur_req = "R6";
        apply_reset(3'd1, 0, 0);
        repeat (2) @(negedge clk);
        key_write(8'hAA);
        chk(rst_req == 1'b1, "R6 second key without first", int'(rst_req), 1);
        apply_reset(3'd1, 0, 0);
        key_write(8'h55);
        key_write(8'h55);
        chk(rst_req == 1'b1, "R6 first key twice", int'(rst_req), 1);

        // R7 window boundary
        cur_req = "R7";
        apply_reset(3'd1, 1, 0);
        wait_cnt(11);
        key_write(8'h55);
        chk(rst_req == 1'b1, "R7 write one tick early", int'(rst_req), 1);
        apply_reset(3'd1, 1, 0);
        wait_cnt(12);
        key_write(8'h55);
        key_write(8'hAA);
        chk(rst_req == 1'b0, "R7 write at window start", int'(rst_req), 0);
        measure(n);
        chk(n == 16, "R7 restart after window service", n, 16);

        // R8 stop mode
        cur_req = "R8";
        apply_reset(3'd1, 0, 0);
        stop_mode = 1'b1;
        p0 = pulses;
        repeat (100) @(negedge clk);
        chk(pulses == p0, "R8 frozen in stop", pulses - p0, 0);
        stop_mode = 1'b0;
        measure(n);
        chk(n == 16, "R8 resumes from frozen count", n, 16);
        apply_reset(3'd1, 0, 1);
        stop_mode = 1'b1;
        measure(n);
        chk(n == 16, "R8 runs in stop when enabled", n, 16);

        // R9 tick gating
        cur_req = "R9";
        apply_reset(3'd1, 0, 0);
        tick_en = 1'b0;
        p0 = pulses;
        repeat (100) @(negedge clk);
        chk(pulses == p0, "R9 no ticks no expiry", pulses - p0, 0);
        for (int i = 0; i < 40; i++) begin
            tick_en = i[0];
            @(negedge clk);
        end
        tick_en = 1'b1;
        chk(pulses == p0 + 1, "R9 expiry after 16 counted ticks", pulses - p0, 1);

        // R2 disabled
        cur_req = "R2";
        apply_reset(3'd0, 0, 0);
        p0 = pulses;
        key_write(8'h00);
        key_write(8'hAA);
        key_write(8'h55);
        key_write(8'h55);
        repeat (50) @(negedge clk);
        chk(pulses == p0, "R2 off ignores writes", pulses - p0, 0);
        cfg_sel = 3'd1;
        measure(n);
        chk(n == 16, "R2 count held at zero while off", n, 16);

        // R11 service on expiring tick
        cur_req = "R11";
        apply_reset(3'd1, 0, 0);
        wait_cnt(13);
        key_write(8'h55);
        wait_cnt(15);
        key_write(8'hAA);
        chk(rst_req == 1'b0, "R11 service wins at expiry", int'(rst_req), 0);
        measure(n);
        chk(n == 16, "R11 restart after boundary service", n, 16);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule